// File: doc/BRIEF.md
# Audio Word-Select Pulse Generator

This block drives one word-select line of a time-slotted serial audio port. It runs on the system clock and advances only on cycles where the bit-clock enable is high. A slot sequencer outside the block supplies three things: a marker one bit before each slot's MSB, a marker on the MSB bit, and a flag for the first slot of a superframe. It also supplies a request bit that says whether the line should be active for the slot that is starting. From these, the block builds one of four pulse shapes and registers the result onto the line.

A second selector sets the line function. The line can be an undriven input, and a rising edge on it then produces a one-cycle reset pulse for the slot pointer. It can also be an active-high driven output or an active-low driven output.

Both selectors are captured only on the pre-MSB bit tick. A change in the middle of a slot therefore cannot cut a pulse short or start one partway through.

Top module: `ws_pulse_gen`

## Requirements
- R1: While `rst_ni` is low, `ws_o`, `ws_oe_o` and `ptr_rst_o` are all 0.
- R2: Style 00 (early framing). On a bit tick with `pre_msb_i`=1, the line level takes `sel_i` and holds it until the next such tick. The line is therefore active from one bit before the MSB up to one bit before the next MSB.
- R3: Style 01 (slot aligned). On a bit tick with `msb_i`=1, the line level takes `sel_i` and holds it until the next MSB tick.
- R4: Style 10 (lead strobe). On each bit tick the line level becomes `pre_msb_i & sel_i`. The result is a one-bit strobe whose trailing edge coincides with the start of the slot.
- R5: Style 11 (short strobe). On an MSB tick the level becomes `sel_i`. On the next bit tick it becomes `sel_i & sf_first_i`, using the values sampled at the MSB tick. After that it is 0. The strobe is therefore one bit long, or two bits long in the first slot of a superframe.
- R6: Function 00 (input). `ws_oe_o`=0 and `ws_o`=0. A 0-to-1 change of `ws_in_i` passes through a two-flop synchroniser. If `ws_in_i` is first sampled high at clock edge k, `ptr_rst_o` is high for exactly the one cycle after edge k+1.
- R7: Functions 01 and 10 drive the line active high, with `ws_oe_o`=1.
- R8: Function 11 drives the line active low, with `ws_oe_o`=1. The computed level is inverted into the output register.
- R9: `style_i` and `func_i` are captured only on a bit tick with `pre_msb_i`=1. The captured values already govern the output register on that same tick. Changes at any other time have no effect until then.
- R10: In functions 01, 10 and 11, `ws_in_i` is ignored and `ptr_rst_o` stays 0.
- R11: `ws_o` and `ws_oe_o` change only on the clock edge of a cycle in which `bit_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-clock enable, one cycle per serial bit |
| pre_msb_i | input | 1 | Marks the bit one before a slot's MSB |
| msb_i | input | 1 | Marks a slot's MSB bit |
| sf_first_i | input | 1 | With `msb_i`, marks the first slot of a superframe |
| sel_i | input | 1 | Sequencer request: line active for the starting slot |
| style_i | input | 2 | Pulse style: 00 early, 01 slot aligned, 10 lead strobe, 11 short strobe |
| func_i | input | 2 | Line function: 00 input, 01/10 active high, 11 active low |
| ws_in_i | input | 1 | Line level when used as input |
| ws_o | output | 1 | Registered line level |
| ws_oe_o | output | 1 | Output enable for the line |
| ptr_rst_o | output | 1 | One-cycle slot pointer reset request |

## Verification
The tightest coincidence is a selector capture that falls on the same pre-MSB tick that starts an early-framing or lead-strobe pulse. On that tick the new style and function must already shape the registered level. The bench changes both selectors in the middle of a slot and holds them through the next pre-MSB tick. It does this for every style and function pair, at a bit-enable rate of one and of three, and compares every clock against a behavioural model. Any mismatch in the slot that follows a change is reported under R9. Edges on the input line keep arriving across every function change, so the model also judges whether a pointer-reset pulse that is already in the synchroniser survives or is suppressed once the line leaves input mode.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    STY_EARLY = 2'b00,
    STY_SLOT  = 2'b01,
    STY_LEAD  = 2'b10,
    STY_SHORT = 2'b11
  } ws_style_e;

  typedef enum logic [SEL_W-1:0] {
    FN_INPUT = 2'b00,
    FN_HIGH_A = 2'b01,
    FN_HIGH_B = 2'b10,
    FN_LOW   = 2'b11
  } ws_func_e;
endpackage

// File: rtl/ws_sel_shadow.sv
module ws_sel_shadow
  import ws_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cap_i,
  input  ws_style_e style_i,
  input  ws_func_e  func_i,
  output ws_style_e style_o,
  output ws_func_e  func_o,
  output ws_func_e  func_q_o
);
  ws_style_e style_q;
  ws_func_e  func_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      style_q <= STY_EARLY;
      func_q  <= FN_INPUT;
    end else if (cap_i) begin
      style_q <= style_i;
      func_q  <= func_i;
    end
  end

  // new selection governs the capture tick itself
  assign style_o  = cap_i ? style_i : style_q;
  assign func_o   = cap_i ? func_i  : func_q;
  assign func_q_o = func_q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(func_q) && $stable(style_q)); // R9
endmodule

// File: rtl/ws_shape.sv
module ws_shape
  import ws_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  input  logic      pre_msb_i,
  input  logic      msb_i,
  input  logic      sf_first_i,
  input  logic      sel_i,
  input  ws_style_e style_i,
  output logic      act_o
);
  logic act_q, ext_q;
  logic act_d, ext_d;

  always_comb begin
    act_d = act_q;
    ext_d = 1'b0;
    unique case (style_i)
      STY_EARLY: if (pre_msb_i) act_d = sel_i;
      STY_SLOT:  if (msb_i) act_d = sel_i;
      STY_LEAD:  act_d = pre_msb_i & sel_i;
      STY_SHORT: begin
        if (msb_i) begin
          act_d = sel_i;
          ext_d = sel_i & sf_first_i;
        end else begin
          act_d = ext_q;
        end
      end
      default: act_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ext_q <= 1'b0;
    end else if (bit_en_i) begin
      act_q <= act_d;
      ext_q <= ext_d;
    end
  end

  assign act_o = act_d;

  AST_LEAD_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && style_i == STY_LEAD && !pre_msb_i |=> !act_q); // R4
  AST_SHORT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && style_i == STY_SHORT && !msb_i && !ext_q |=> !act_q); // R5
endmodule

// File: rtl/ws_edge_sync.sv
module ws_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/ws_pulse_gen.sv
module ws_pulse_gen
  import ws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             pre_msb_i,
  input  logic             msb_i,
  input  logic             sf_first_i,
  input  logic             sel_i,
  input  logic [SEL_W-1:0] style_i,
  input  logic [SEL_W-1:0] func_i,
  input  logic             ws_in_i,
  output logic             ws_o,
  output logic             ws_oe_o,
  output logic             ptr_rst_o
);
  logic      cap;
  ws_style_e style_eff;
  ws_func_e  func_eff, func_q;
  logic      act;
  logic      rise;
  logic      ws_q, oe_q;

  assign cap = bit_en_i & pre_msb_i;

  ws_sel_shadow u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .style_i  (ws_style_e'(style_i)),
    .func_i   (ws_func_e'(func_i)),
    .style_o  (style_eff),
    .func_o   (func_eff),
    .func_q_o (func_q)
  );

  ws_shape u_shape (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .pre_msb_i  (pre_msb_i),
    .msb_i      (msb_i),
    .sf_first_i (sf_first_i),
    .sel_i      (sel_i),
    .style_i    (style_eff),
    .act_o      (act)
  );

  ws_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ws_in_i),
    .rise_o (rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q <= 1'b0;
      oe_q <= 1'b0;
    end else if (bit_en_i) begin
      oe_q <= (func_eff != FN_INPUT);
      unique case (func_eff)
        FN_INPUT: ws_q <= 1'b0;
        FN_LOW:   ws_q <= ~act;
        default:  ws_q <= act;
      endcase
    end
  end

  assign ws_o      = ws_q;
  assign ws_oe_o   = oe_q;
  assign ptr_rst_o = rise & (func_q == FN_INPUT);

  AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ws_oe_o |-> !ws_o); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(ws_o) && $stable(ws_oe_o)); // R11
  AST_NO_PTR_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_o |-> !ws_oe_o); // R10
endmodule

// File: tb/sim_ws_pulse_gen.sv
module sim_ws_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_LEN   = 6;
  localparam int SLOTS      = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, pre_msb = 1'b0, msb = 1'b0, sf_first = 1'b0, sel = 1'b0;
  logic [1:0] style = 2'b00, func = 2'b00;
  logic ws_in = 1'b0;
  logic ws, oe, ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ws_pulse_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .pre_msb_i(pre_msb),
    .msb_i(msb), .sf_first_i(sf_first), .sel_i(sel), .style_i(style),
    .func_i(func), .ws_in_i(ws_in), .ws_o(ws), .ws_oe_o(oe), .ptr_rst_o(ptr)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  int  m_style, m_func;
  bit  m_act, m_ext, m_ws, m_oe;
  bit  in_hist[$];
  bit  m_prev_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_style = 0; m_func = 0; m_act = 0; m_ext = 0; m_ws = 0; m_oe = 0;
      in_hist = {0, 0, 0};
      m_prev_en = 0;
    end else begin
      in_hist.push_front(ws_in);
      void'(in_hist.pop_back());
      m_prev_en = bit_en;
      if (bit_en) begin
        if (pre_msb) begin m_style = style; m_func = func; end // R9
        if (m_style == 0) begin if (pre_msb) m_act = sel; m_ext = 0; end
        else if (m_style == 1) begin if (msb) m_act = sel; m_ext = 0; end
        else if (m_style == 2) begin m_act = pre_msb && sel; m_ext = 0; end
        else begin
          if (msb) begin m_act = sel; m_ext = sel && sf_first; end
          else begin m_act = m_ext; m_ext = 0; end
        end
        m_oe = (m_func != 0);
        m_ws = (m_func == 0) ? 0 : ((m_func == 3) ? !m_act : m_act);
      end
    end
  end

  int since_change = 1000;

  task automatic check_all();
    bit m_ptr;
    string tw, to, tp;
    m_ptr = in_hist[1] && !in_hist[2] && (m_func == 0);
    if (m_func == 0) tw = "R6";
    else begin
      case (m_style)
        0: tw = "R2"; 1: tw = "R3"; 2: tw = "R4"; default: tw = "R5";
      endcase
      if (m_func == 3) tw = {tw, "/R8"};
    end
    if (!m_prev_en) tw = {tw, "/R11"};
    if (since_change < 3 * SLOT_LEN * SLOTS) tw = {tw, "/R9"};
    to = (m_func == 0) ? "R6" : "R7";
    tp = (m_func == 0) ? "R6" : "R10";
    n_cmp++;
    if (ws !== m_ws) begin
      n_bad++; $display("FAIL %s ws_o act=%0b exp=%0b t=%0t", tw, ws, m_ws, $time);
    end
    if (oe !== m_oe) begin
      n_bad++; $display("FAIL %s ws_oe_o act=%0b exp=%0b t=%0t", to, oe, m_oe, $time);
    end
    if (ptr !== m_ptr) begin
      n_bad++; $display("FAIL %s ptr_rst_o act=%0b exp=%0b t=%0t", tp, ptr, m_ptr, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  int bitpos = 0, slot = 0, cyc = 0, div = 1;
  bit [7:0] lfsr = 8'h5a;

  task automatic step();
    @(negedge clk);
    check_all();
    since_change++;
    if (bit_en) begin
      bitpos++;
      if (bitpos == SLOT_LEN) begin bitpos = 0; slot = (slot + 1) % SLOTS; end
      if (bitpos == 2) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        sel = lfsr[0] | lfsr[2];
      end
    end
    cyc++;
    bit_en   = (cyc % div) == 0;
    pre_msb  = (bitpos == SLOT_LEN - 1);
    msb      = (bitpos == 0);
    sf_first = (bitpos == 0) && (slot == 0);
    if ($urandom_range(0, 6) == 0) ws_in = ~ws_in;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    n_cmp++;
    if (ws !== 0 || oe !== 0 || ptr !== 0) begin
      n_bad++;
      $display("FAIL R1 reset act=%0b%0b%0b exp=000", ws, oe, ptr);
    end
    rst_n = 1'b1;
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 4; s++) begin
        for (int d = 0; d < 2; d++) begin
          div = (d == 0) ? 1 : 3;
          // change selectors mid-slot: capture waits for pre-MSB tick (R9)
          while (bitpos != 2) step();
          style = s[1:0];
          func  = f[1:0];
          since_change = 0;
          repeat (SLOT_LEN * SLOTS * 3 * div) step();
        end
      end
    end
    // revisit input mode after driven modes (R6, R10)
    while (bitpos != 3) step();
    func = 2'b00;
    since_change = 0;
    repeat (300) step();
    summary();
  end
endmodule